// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

An 8-bit arithmetic and logic unit for an accumulator-based microcontroller datapath. Each cycle it may accept an operation on the accumulator byte and a second operand byte. With the operation it takes the incoming carry and auxiliary-carry flags. One clock later it presents a primary result byte for the accumulator and a secondary result byte for the helper register that multiply and divide use. It also presents new values for the carry, auxiliary-carry, overflow and parity flags. Each flag comes with its own write-enable, so the surrounding core can update only the flags the operation class owns.

The supported operations are binary add (plain and with carry), subtract with borrow, increment, decrement, 8x8 multiply, 8/8 divide with a divide-by-zero indication, and decimal adjust after a BCD addition. It also provides bitwise AND, OR and XOR, clear, complement, rotates left and right (plain and through carry), and nibble swap. Operand fetch, the register file and instruction decode belong to the surrounding core.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `res_valid`, both result bytes, all flag values and all four flag write-enables are 0 after that edge.
- R2: Results appear exactly one clock after the operation is accepted: `res_valid` after an edge equals `op_valid` before it. The `op` code values are ADD=0, ADDC=1, SUBB=2, INC=3, DEC=4, MUL=5, DIV=6, DA=7, AND=8, OR=9, XOR=10, CLR=11, CPL=12, RL=13, RLC=14, RR=15, RRC=16, SWAP=17.
- R3: ADD gives acc+opd and ADDC gives acc+opd+carry_in. Carry is the carry out of bit 7, auxiliary carry is the carry out of bit 3, and overflow is the two's-complement overflow. All four flag enables are set.
- R4: SUBB gives acc-opd-carry_in. Carry is set on a borrow out of bit 7, auxiliary carry is set on a borrow out of bit 3, and overflow is the signed overflow. All four flag enables are set.
- R5: INC and DEC give acc+1 and acc-1, wrapping modulo 256, with every flag enable clear.
- R6: AND, OR and XOR combine acc with opd bitwise. CLR gives 0, CPL gives the inverted acc, and SWAP gives acc with its upper and lower nibbles exchanged. None of these six sets any flag enable.
- R7: RL and RR rotate acc by one bit, left and right, with no flag enable. RLC shifts carry_in into bit 0 and moves old bit 7 into carry. RRC shifts carry_in into bit 7 and moves old bit 0 into carry. Both through-carry rotates set only the carry enable.
- R8: MUL puts the low byte of acc*opd on the primary result and the high byte on the secondary result. It clears carry and sets overflow exactly when the high byte is non-zero. The carry, overflow and parity enables are set.
- R9: DIV with a non-zero opd gives the quotient on the primary result and the remainder on the secondary result, with carry and overflow cleared. With opd equal to 0, overflow is set and both result bytes are unspecified. The carry, overflow and parity enables are set.
- R10: DA adds 6 when the low nibble exceeds 9 or auxiliary carry is set. It then adds 0x60 when the high nibble exceeds 9 or the carry (incoming or produced by the first step) is set. Carry out is set if carry_in was set or either step carried out of bit 7, so it is never cleared. The carry and parity enables are set.
- R11: The parity flag value is 1 exactly when the primary result has an odd number of ones. Its enable is set for ADD, ADDC, SUBB, MUL, DIV and DA only.
- R12: The secondary result is 0 for every operation other than MUL and DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code (values in R2) |
| acc_in | input | 8 | Accumulator operand |
| opd_in | input | 8 | Second operand (multiply/divide helper register or source byte) |
| cy_in | input | 1 | Incoming carry flag |
| ac_in | input | 1 | Incoming auxiliary-carry flag |
| res_valid | output | 1 | Result registers hold a fresh result |
| res_a | output | 8 | Primary result for the accumulator |
| res_b | output | 8 | Secondary result (product high byte or remainder) |
| cy_o | output | 1 | New carry value |
| ac_o | output | 1 | New auxiliary-carry value |
| ov_o | output | 1 | New overflow value |
| p_o | output | 1 | New parity value |
| cy_we | output | 1 | Carry write-enable |
| ac_we | output | 1 | Auxiliary-carry write-enable |
| ov_we | output | 1 | Overflow write-enable |
| p_we | output | 1 | Parity write-enable |

## Verification
Decimal adjust is the hardest case to reach, because the second correction depends on a carry produced by the first. A byte such as 0xFA with auxiliary carry set overflows out of bit 7 while adding 6. That carry must then force the 0x60 correction even though the high nibble of the partial sum is small. Directed vectors place the operand at these nibble boundaries (0x9A, 0xFA, 0x20 with carry in, 0x81 with auxiliary carry). Randomised flag inputs then cover the remaining combinations. Divide by zero and the signed-overflow edges of subtract with borrow (0x00-0x7F-1, 0x80-0x00-1) are also driven explicitly.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUBB = 5'd2,  OP_INC  = 5'd3,
    OP_DEC  = 5'd4,  OP_MUL  = 5'd5,  OP_DIV  = 5'd6,  OP_DA   = 5'd7,
    OP_AND  = 5'd8,  OP_OR   = 5'd9,  OP_XOR  = 5'd10, OP_CLR  = 5'd11,
    OP_CPL  = 5'd12, OP_RL   = 5'd13, OP_RLC  = 5'd14, OP_RR   = 5'd15,
    OP_RRC  = 5'd16, OP_SWAP = 5'd17
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
    logic p;
  } flag_set_t;
endpackage

// File: rtl/acc_addsub.sv
module acc_addsub
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cy_i,
  output logic [DATA_W-1:0] r,
  output logic              cy,
  output logic              ac,
  output logic              ov
);
  localparam int HALF_W = DATA_W / 2;

  logic              cin;
  logic [DATA_W:0]   wide;
  logic [HALF_W:0]   low;
  logic [DATA_W:0]   sx;

  always_comb begin
    cin = (op == OP_ADDC || op == OP_SUBB) ? cy_i : 1'b0;
    case (op)
      OP_INC:  wide = {1'b0, a} + (DATA_W+1)'(1);
      OP_DEC:  wide = {1'b0, a} - (DATA_W+1)'(1);
      OP_SUBB: wide = {1'b0, a} - {1'b0, b} - (DATA_W+1)'(cin);
      default: wide = {1'b0, a} + {1'b0, b} + (DATA_W+1)'(cin);
    endcase
    if (op == OP_SUBB) begin
      low = {1'b0, a[HALF_W-1:0]} - {1'b0, b[HALF_W-1:0]} - (HALF_W+1)'(cin);
      sx  = {a[DATA_W-1], a} - {b[DATA_W-1], b} - (DATA_W+1)'(cin);
    end else begin
      low = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]} + (HALF_W+1)'(cin);
      sx  = {a[DATA_W-1], a} + {b[DATA_W-1], b} + (DATA_W+1)'(cin);
    end
    r  = wide[DATA_W-1:0];
    cy = wide[DATA_W];
    ac = low[HALF_W];
    ov = sx[DATA_W] ^ sx[DATA_W-1];
  end
endmodule

// File: rtl/acc_muldiv.sv
module acc_muldiv #(
  parameter int DATA_W = 8
) (
  input  logic              is_div,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] lo,
  output logic [DATA_W-1:0] hi,
  output logic              ov
);
  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] prod;
  logic              b_zero;

  always_comb begin
    prod   = PROD_W'(a) * PROD_W'(b);
    b_zero = (b == '0);
    if (is_div) begin
      if (b_zero) begin
        lo = '1;
        hi = a;
      end else begin
        lo = a / b;
        hi = a % b;
      end
      ov = b_zero;
    end else begin
      lo = prod[DATA_W-1:0];
      hi = prod[PROD_W-1:DATA_W];
      ov = (prod[PROD_W-1:DATA_W] != '0);
    end
  end
endmodule

// File: rtl/acc_decadj.sv
module acc_decadj #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic              cy_i,
  input  logic              ac_i,
  output logic [DATA_W-1:0] r,
  output logic              cy
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W:0] LO_FIX = (DATA_W+1)'(6);
  localparam logic [DATA_W:0] HI_FIX = (DATA_W+1)'(6) << HALF_W;
  localparam logic [HALF_W-1:0] DIGIT_MAX = HALF_W'(9);

  logic [DATA_W:0] step1;
  logic [DATA_W:0] step2;
  logic            c1;
  logic            fix_hi;

  always_comb begin
    step1  = {1'b0, a};
    if (a[HALF_W-1:0] > DIGIT_MAX || ac_i)
      step1 = {1'b0, a} + LO_FIX;
    c1     = step1[DATA_W];
    fix_hi = (step1[DATA_W-1:HALF_W] > DIGIT_MAX) || cy_i || c1;
    step2  = {1'b0, step1[DATA_W-1:0]};
    if (fix_hi)
      step2 = {1'b0, step1[DATA_W-1:0]} + HI_FIX;
    r  = step2[DATA_W-1:0];
    cy = cy_i | c1 | step2[DATA_W];
  end
endmodule

// File: rtl/acc_bitops.sv
module acc_bitops
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cy_i,
  output logic [DATA_W-1:0] r,
  output logic              cy
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    cy = cy_i;
    case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_CLR:  r = '0;
      OP_CPL:  r = ~a;
      OP_RL:   r = {a[DATA_W-2:0], a[DATA_W-1]};
      OP_RR:   r = {a[0], a[DATA_W-1:1]};
      OP_RLC: begin
        r  = {a[DATA_W-2:0], cy_i};
        cy = a[DATA_W-1];
      end
      OP_RRC: begin
        r  = {cy_i, a[DATA_W-1:1]};
        cy = a[0];
      end
      OP_SWAP: r = {a[HALF_W-1:0], a[DATA_W-1:HALF_W]};
      default: r = a;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [4:0]        op,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opd_in,
  input  logic              cy_in,
  input  logic              ac_in,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_a,
  output logic [DATA_W-1:0] res_b,
  output logic              cy_o,
  output logic              ac_o,
  output logic              ov_o,
  output logic              p_o,
  output logic              cy_we,
  output logic              ac_we,
  output logic              ov_we,
  output logic              p_we
);
  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  logic [DATA_W-1:0] as_r, md_lo, md_hi, da_r, bo_r;
  logic              as_cy, as_ac, as_ov, md_ov, da_cy, bo_cy;

  acc_addsub #(.DATA_W(DATA_W)) u_addsub (
    .op(op_e), .a(acc_in), .b(opd_in), .cy_i(cy_in),
    .r(as_r), .cy(as_cy), .ac(as_ac), .ov(as_ov)
  );

  acc_muldiv #(.DATA_W(DATA_W)) u_muldiv (
    .is_div(op_e == OP_DIV), .a(acc_in), .b(opd_in),
    .lo(md_lo), .hi(md_hi), .ov(md_ov)
  );

  acc_decadj #(.DATA_W(DATA_W)) u_decadj (
    .a(acc_in), .cy_i(cy_in), .ac_i(ac_in), .r(da_r), .cy(da_cy)
  );

  acc_bitops #(.DATA_W(DATA_W)) u_bitops (
    .op(op_e), .a(acc_in), .b(opd_in), .cy_i(cy_in), .r(bo_r), .cy(bo_cy)
  );

  logic [DATA_W-1:0] nxt_a, nxt_b;
  flag_set_t         nxt_f, nxt_we;

  always_comb begin
    nxt_a  = bo_r;
    nxt_b  = '0;
    nxt_f  = '0;
    nxt_we = '0;
    case (op_e)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        nxt_a  = as_r;
        nxt_f  = '{cy: as_cy, ac: as_ac, ov: as_ov, p: 1'b0};
        nxt_we = '{cy: 1'b1, ac: 1'b1, ov: 1'b1, p: 1'b1};
      end
      OP_INC, OP_DEC: nxt_a = as_r;
      OP_MUL, OP_DIV: begin
        nxt_a  = md_lo;
        nxt_b  = md_hi;
        nxt_f  = '{cy: 1'b0, ac: 1'b0, ov: md_ov, p: 1'b0};
        nxt_we = '{cy: 1'b1, ac: 1'b0, ov: 1'b1, p: 1'b1};
      end
      OP_DA: begin
        nxt_a  = da_r;
        nxt_f  = '{cy: da_cy, ac: 1'b0, ov: 1'b0, p: 1'b0};
        nxt_we = '{cy: 1'b1, ac: 1'b0, ov: 1'b0, p: 1'b1};
      end
      OP_RLC, OP_RRC: begin
        nxt_f.cy  = bo_cy;
        nxt_we.cy = 1'b1;
      end
      default: ;
    endcase
    nxt_f.p = ^nxt_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_a     <= '0;
      res_b     <= '0;
      {cy_o, ac_o, ov_o, p_o}     <= '0;
      {cy_we, ac_we, ov_we, p_we} <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_a <= nxt_a;
        res_b <= nxt_b;
        {cy_o, ac_o, ov_o, p_o}     <= nxt_f;
        {cy_we, ac_we, ov_we, p_we} <= nxt_we;
      end else begin
        {cy_we, ac_we, ov_we, p_we} <= '0;
      end
    end
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  // R5
  incdec_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_e == OP_INC || op_e == OP_DEC))
      |=> !(cy_we || ac_we || ov_we || p_we));

  // R6
  logic_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_e == OP_AND || op_e == OP_OR || op_e == OP_XOR ||
                  op_e == OP_CLR || op_e == OP_CPL || op_e == OP_SWAP ||
                  op_e == OP_RL  || op_e == OP_RR))
      |=> !(cy_we || ac_we || ov_we || p_we));

  // R7
  rotc_carry_only_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_e == OP_RLC || op_e == OP_RRC))
      |=> (cy_we && !ac_we && !ov_we && !p_we));

  // R8
  mul_carry_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_e == OP_MUL) |=> (cy_we && !cy_o));

  // R9
  div_zero_ov_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_e == OP_DIV && opd_in == '0) |=> (ov_we && ov_o));

  // R10
  da_sticky_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_e == OP_DA && cy_in) |=> (cy_we && cy_o));
endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] acc_in = '0, opd_in = '0;
  logic       cy_in = 1'b0, ac_in = 1'b0;
  logic       res_valid;
  logic [7:0] res_a, res_b;
  logic       cy_o, ac_o, ov_o, p_o, cy_we, ac_we, ov_we, p_we;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(op),
    .acc_in(acc_in), .opd_in(opd_in), .cy_in(cy_in), .ac_in(ac_in),
    .res_valid(res_valid), .res_a(res_a), .res_b(res_b),
    .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o), .p_o(p_o),
    .cy_we(cy_we), .ac_we(ac_we), .ov_we(ov_we), .p_we(p_we)
  );

  typedef struct {
    int         opc;
    logic [7:0] ra, rb;
    logic       cy, ac, ov, p;
    logic [3:0] we;
    bit         chk_res;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0, cyc = 0;
  bit   done = 0;
  logic prev_iv = 1'b0;

  function automatic string req_of(int o);
    case (o)
      0, 1:                  return "R3";
      2:                     return "R4";
      3, 4:                  return "R5";
      5:                     return "R8";
      6:                     return "R9";
      7:                     return "R10";
      13, 14, 15, 16:        return "R7";
      default:               return "R6";
    endcase
  endfunction

  function automatic int sgn(logic [7:0] v);
    return (v > 127) ? int'(v) - 256 : int'(v);
  endfunction

  function automatic exp_t model(int o, logic [7:0] a, logic [7:0] b, logic c, logic h);
    exp_t e;
    int   v, s;
    e.opc = o; e.ra = 0; e.rb = 0; e.cy = 0; e.ac = 0; e.ov = 0;
    e.we = 4'b0000; e.chk_res = 1;
    case (o)
      0, 1: begin
        v = int'(a) + int'(b) + ((o == 1) ? int'(c) : 0);
        e.ra = v[7:0]; e.cy = (v > 255);
        e.ac = ((int'(a & 8'h0F) + int'(b & 8'h0F) + ((o == 1) ? int'(c) : 0)) > 15);
        s = sgn(a) + sgn(b) + ((o == 1) ? int'(c) : 0);
        e.ov = (s > 127 || s < -128); e.we = 4'b1111;
      end
      2: begin
        v = int'(a) - int'(b) - int'(c);
        e.ra = v[7:0]; e.cy = (v < 0);
        e.ac = (int'(a & 8'h0F) < int'(b & 8'h0F) + int'(c));
        s = sgn(a) - sgn(b) - int'(c);
        e.ov = (s > 127 || s < -128); e.we = 4'b1111;
      end
      3: e.ra = a + 8'd1;
      4: e.ra = a - 8'd1;
      5: begin
        v = int'(a) * int'(b);
        e.ra = v[7:0]; e.rb = v[15:8]; e.ov = (v > 255); e.we = 4'b1011;
      end
      6: begin
        if (b == 0) begin e.ov = 1; e.chk_res = 0; end
        else begin e.ra = a / b; e.rb = a % b; end
        e.we = 4'b1011;
      end
      7: begin
        v = int'(a); e.cy = c;
        if ((v % 16) > 9 || h) v = v + 6;
        if (v > 255) begin e.cy = 1; v = v - 256; end
        if ((v / 16) > 9 || e.cy) v = v + 96;
        if (v > 255) begin e.cy = 1; v = v - 256; end
        e.ra = v[7:0]; e.we = 4'b1001;
      end
      8:  e.ra = a & b;
      9:  e.ra = a | b;
      10: e.ra = a ^ b;
      11: e.ra = 8'h00;
      12: e.ra = ~a;
      13: e.ra = {a[6:0], a[7]};
      14: begin e.ra = {a[6:0], c}; e.cy = a[7]; e.we = 4'b1000; end
      15: e.ra = {a[0], a[7:1]};
      16: begin e.ra = {c, a[7:1]}; e.cy = a[0]; e.we = 4'b1000; end
      default: e.ra = {a[3:0], a[7:4]};
    endcase
    e.p = ^e.ra;
    return e;
  endfunction

  task automatic apply(int o, logic [7:0] a, logic [7:0] b, logic c, logic h);
    @(negedge clk);
    op_valid = 1'b1; op = o[4:0]; acc_in = a; opd_in = b; cy_in = c; ac_in = h;
    q.push_back(model(o, a, b, c, h));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 1'b0;
    end
  endtask

  always @(posedge clk) prev_iv <= rst ? 1'b0 : op_valid;

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (res_valid !== prev_iv) begin
        n_chk++; n_fail++;
        $display("FAIL R2 res_valid actual=%b expected=%b", res_valid, prev_iv);
      end
      if (res_valid === 1'b1) begin
        if (q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R2 unexpected result actual=1 expected=0");
        end else begin
          exp_t e;
          logic [3:0] we_act;
          e = q.pop_front();
          we_act = {cy_we, ac_we, ov_we, p_we};
          n_chk++;
          if (we_act !== e.we) begin
            n_fail++;
            $display("FAIL %s op=%0d enables actual=%b expected=%b", req_of(e.opc), e.opc, we_act, e.we);
          end else if (e.chk_res && res_a !== e.ra) begin
            n_fail++;
            $display("FAIL %s op=%0d res_a actual=%h expected=%h", req_of(e.opc), e.opc, res_a, e.ra);
          end else if (e.chk_res && res_b !== e.rb) begin
            n_fail++;
            $display("FAIL %s R12 op=%0d res_b actual=%h expected=%h", req_of(e.opc), e.opc, res_b, e.rb);
          end else if (e.we[3] && cy_o !== e.cy) begin
            n_fail++;
            $display("FAIL %s op=%0d carry actual=%b expected=%b", req_of(e.opc), e.opc, cy_o, e.cy);
          end else if (e.we[2] && ac_o !== e.ac) begin
            n_fail++;
            $display("FAIL %s op=%0d aux carry actual=%b expected=%b", req_of(e.opc), e.opc, ac_o, e.ac);
          end else if (e.we[1] && ov_o !== e.ov) begin
            n_fail++;
            $display("FAIL %s op=%0d overflow actual=%b expected=%b", req_of(e.opc), e.opc, ov_o, e.ov);
          end else if (e.we[0] && e.chk_res && p_o !== e.p) begin
            n_fail++;
            $display("FAIL R11 op=%0d parity actual=%b expected=%b", e.opc, p_o, e.p);
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYCLES && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected<=%0d", cyc, MAX_CYCLES);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    op_valid = 1'b1; op = 5'd0; acc_in = 8'hFF; opd_in = 8'h01;
    repeat (3) @(negedge clk);
    n_chk++;
    if ({res_valid, res_a, res_b, cy_o, ac_o, ov_o, p_o, cy_we, ac_we, ov_we, p_we} !== '0) begin
      n_fail++;
      $display("FAIL R1 reset outputs actual=%b%h%h expected=0", res_valid, res_a, res_b);
    end
    op_valid = 1'b0;
    rst = 1'b0;

    // R3 add corners
    apply(0, 8'hFF, 8'h01, 1'b1, 1'b0);
    apply(0, 8'h7F, 8'h01, 1'b0, 1'b0);
    apply(1, 8'h0F, 8'h00, 1'b1, 1'b0);
    apply(1, 8'h80, 8'h7F, 1'b1, 1'b0);
    // R4 subtract corners
    apply(2, 8'h00, 8'h01, 1'b0, 1'b0);
    apply(2, 8'h00, 8'h7F, 1'b1, 1'b0);
    apply(2, 8'h80, 8'h00, 1'b1, 1'b0);
    apply(2, 8'h10, 8'h01, 1'b0, 1'b0);
    // R5 wrap
    apply(3, 8'hFF, 8'h00, 1'b1, 1'b1);
    apply(4, 8'h00, 8'h00, 1'b0, 1'b0);
    idle(2);
    // R8 multiply
    apply(5, 8'hFF, 8'hFF, 1'b1, 1'b0);
    apply(5, 8'h10, 8'h02, 1'b1, 1'b0);
    // R9 divide
    apply(6, 8'hFB, 8'h12, 1'b1, 1'b0);
    apply(6, 8'h05, 8'h00, 1'b0, 1'b0);
    // R10 decimal adjust
    apply(7, 8'h81, 8'h00, 1'b0, 1'b1);
    apply(7, 8'h20, 8'h00, 1'b1, 1'b0);
    apply(7, 8'h9A, 8'h00, 1'b0, 1'b0);
    apply(7, 8'hFA, 8'h00, 1'b0, 1'b1);
    apply(7, 8'h45, 8'h00, 1'b0, 1'b0);
    // R6, R7 logic, swap, rotates
    apply(17, 8'hA5, 8'h00, 1'b1, 1'b1);
    apply(14, 8'h80, 8'h00, 1'b0, 1'b0);
    apply(16, 8'h01, 8'h00, 1'b0, 1'b0);
    apply(14, 8'h00, 8'h00, 1'b1, 1'b0);
    apply(13, 8'h81, 8'h00, 1'b1, 1'b0);
    apply(15, 8'h81, 8'h00, 1'b0, 1'b0);
    apply(11, 8'h5A, 8'hFF, 1'b1, 1'b1);
    apply(12, 8'h5A, 8'h00, 1'b0, 1'b0);
    idle(1);

    // randomised sweep over every op; R11 parity and R12 checked throughout
    for (int r = 0; r < 150; r++) begin
      for (int o = 0; o < 18; o++) begin
        apply(o, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
      end
      if (r % 10 == 0) idle(1);
    end
    idle(3);
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 pending results actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule